// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Core

This core encrypts or decrypts one 64-bit block with a 16-round Feistel network, doing one round per clock. Each round takes one 32-bit half, combines it with that round's masking word, rotates the result left by the round's 5-bit rotate amount, and splits the rotated word into four bytes. Each byte indexes its own 256-entry substitution table. The four table outputs are folded into one word, and that word is XORed into the other half. The round number picks one of three mixing variants. Each variant has its own order of add, XOR and subtract.

The core does no key expansion. A host writes the 16 masking words and 16 rotate amounts into a small key file, and loads the four substitution tables through a table write port. A block is then started with a one-cycle pulse that carries the mode and the data. A shortened 12-round schedule can be chosen for each block, as used with short keys.

Top module: `feistel_core`

## Requirements
- R1: After reset, `valid_o` and `busy_o` are low and `block_o` is all zeros.
- R2: Encryption loads left = `block_i[63:32]` and right = `block_i[31:0]`, then runs rounds 0, 1, 2 and so on. An even round XORs the round function of right into left. An odd round XORs the round function of left into right. The result is `{right, left}`. With every table entry zero, the result is the input with its halves swapped.
- R3: Decryption loads right = `block_i[63:32]` and left = `block_i[31:0]` and runs the rounds from the last one down to round 0, each round keeping its own variant and its even/odd half rule. The result is `{left, right}`, so decrypting a ciphertext returns the plaintext.
- R4: Round n uses variant n mod 3. Variant 0 forms mask + half and folds the four lookups as ((T0 ^ T1) - T2) + T3. Variant 1 forms mask ^ half and folds them as ((T0 - T1) + T2) ^ T3. Variant 2 forms mask - half and folds them as ((T0 + T1) ^ T2) - T3. All arithmetic is modulo 2^32.
- R5: The combined word is rotated left before the lookups. T0 is table 0 indexed by bits 31:24 of the rotated word, down to T3, which is table 3 indexed by bits 7:0. A table entry is written when `tbl_we_i` is high, with `tbl_sel_i` (0..3) choosing the table and `tbl_addr_i` the entry.
- R6: A key-file write at `key_addr_i` 0..15 sets the masking word of that round. A write at 16..31 sets the rotate amount of round `key_addr_i - 16`, and only bits 4:0 of the written data are kept.
- R7: With `short_i` high at start, only rounds 0..11 are run. Encryption stops after round 11, and decryption begins at round 11.
- R8: `valid_o` is a one-cycle pulse. It rises at the N-th rising edge after the edge that accepts start, where N is 16, or 12 in short mode. `block_o` changes only at that edge and holds its value until the next result.
- R9: `start_i` is accepted only while `busy_o` is low. `busy_o` stays high from the accepting edge through the cycle in which `valid_o` is high. A start pulse during that time, including the valid cycle itself, has no effect.
- R10: A rotate amount of zero passes the combined word to the lookups unchanged. An amount of 31 moves bit 0 to bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_we_i | input | 1 | Key file write enable |
| key_addr_i | input | 5 | Key file word address (0..15 masking, 16..31 rotate) |
| key_wdata_i | input | 32 | Key file write data |
| tbl_we_i | input | 1 | Substitution table write enable |
| tbl_sel_i | input | 2 | Table select, 0..3 |
| tbl_addr_i | input | 8 | Table entry address |
| tbl_wdata_i | input | 32 | Table write data |
| start_i | input | 1 | Start pulse, sampled while idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt, sampled with start |
| short_i | input | 1 | 1 = 12-round schedule, sampled with start |
| block_i | input | 64 | Input block |
| block_o | output | 64 | Result block, held until the next result |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Core is running rounds or presenting a result |

## Verification
The collision of interest is a new start request arriving in the same cycle that a finished block is being presented on `valid_o`. The output cycle still counts as busy, so the request must be dropped. The bench raises `start_i` with a different block exactly in the cycle where it sees `valid_o` high. It also raises `start_i` once in the middle of a running block. It then checks three things: the presented result still matches the first block's expected ciphertext, `busy_o` falls after the output cycle, and no second `valid_o` pulse or change of `block_o` follows over a window longer than a full run.

// File: rtl/feistel_pkg.sv
package feistel_pkg;

  localparam int unsigned IDX_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OUT  = 2'd2
  } core_state_e;

  typedef enum logic [1:0] {
    MIX_ADD = 2'd0,
    MIX_XOR = 2'd1,
    MIX_SUB = 2'd2
  } mix_kind_e;

  function automatic mix_kind_e mix_kind_of(input logic [7:0] rnd);
    logic [7:0] m;
    m = rnd % 8'd3;
    return mix_kind_e'(m[1:0]);
  endfunction

endpackage

// File: rtl/feistel_key_rf.sv
module feistel_key_rf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ROUNDS = 16,
  parameter int unsigned ROT_W  = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [$clog2(2*ROUNDS)-1:0] addr_i,
  input  logic [WORD_W-1:0]           wdata_i,
  input  logic [$clog2(ROUNDS)-1:0]   rnd_i,
  output logic [WORD_W-1:0]           mask_o,
  output logic [ROT_W-1:0]            rot_o
);

  localparam int unsigned AW = $clog2(2*ROUNDS);

  logic [WORD_W-1:0] mask_arr [ROUNDS];
  logic [ROT_W-1:0]  rot_arr  [ROUNDS];

  for (genvar g = 0; g < ROUNDS; g++) begin : g_ent
    logic [WORD_W-1:0] m_q;
    logic [ROT_W-1:0]  r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m_q <= '0;
        r_q <= '0;
      end else if (we_i) begin
        if (addr_i == AW'(g))          m_q <= wdata_i;
        if (addr_i == AW'(g + ROUNDS)) r_q <= wdata_i[ROT_W-1:0];
      end
    end

    assign mask_arr[g] = m_q;
    assign rot_arr[g]  = r_q;
  end

  assign mask_o = mask_arr[rnd_i];
  assign rot_o  = rot_arr[rnd_i];

endmodule

// File: rtl/feistel_lut_bank.sv
module feistel_lut_bank
  import feistel_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANES  = WORD_W / IDX_W
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [$clog2(LANES)-1:0]   sel_i,
  input  logic [IDX_W-1:0]           addr_i,
  input  logic [WORD_W-1:0]          wdata_i,
  input  logic [WORD_W-1:0]          idx_i,
  output logic [LANES*WORD_W-1:0]    lut_o
);

  localparam int unsigned SEL_W = $clog2(LANES);
  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && sel_i == SEL_W'(g)) mem[addr_i] <= wdata_i;
    end

    // lane 0 takes the most significant byte
    assign lut_o[g*WORD_W +: WORD_W] = mem[idx_i[WORD_W-1-g*IDX_W -: IDX_W]];
  end

endmodule

// File: rtl/feistel_round_fn.sv
module feistel_round_fn
  import feistel_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ROT_W  = 5,
  parameter int unsigned LANES  = WORD_W / IDX_W
) (
  input  logic [WORD_W-1:0]       half_i,
  input  logic [WORD_W-1:0]       mask_i,
  input  logic [ROT_W-1:0]        rot_i,
  input  mix_kind_e               kind_i,
  output logic [WORD_W-1:0]       idx_o,
  input  logic [LANES*WORD_W-1:0] lut_i,
  output logic [WORD_W-1:0]       f_o
);

  logic [WORD_W-1:0]   pre;
  logic [2*WORD_W-1:0] dbl;
  logic [WORD_W-1:0]   ta, tb, tc, td;

  always_comb begin
    unique case (kind_i)
      MIX_XOR: pre = mask_i ^ half_i;
      MIX_SUB: pre = mask_i - half_i;
      default: pre = mask_i + half_i;
    endcase
  end

  assign dbl   = {pre, pre} << rot_i;
  assign idx_o = dbl[2*WORD_W-1:WORD_W];

  assign ta = lut_i[0*WORD_W +: WORD_W];
  assign tb = lut_i[1*WORD_W +: WORD_W];
  assign tc = lut_i[2*WORD_W +: WORD_W];
  assign td = lut_i[3*WORD_W +: WORD_W];

  always_comb begin
    unique case (kind_i)
      MIX_XOR: f_o = ((ta - tb) + tc) ^ td;
      MIX_SUB: f_o = ((ta + tb) ^ tc) - td;
      default: f_o = ((ta ^ tb) - tc) + td;
    endcase
  end

endmodule

// File: rtl/feistel_core.sv
module feistel_core
  import feistel_pkg::*;
#(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned ROUNDS       = 16,
  parameter int unsigned SHORT_ROUNDS = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        key_we_i,
  input  logic [$clog2(2*ROUNDS)-1:0] key_addr_i,
  input  logic [WORD_W-1:0]           key_wdata_i,
  input  logic                        tbl_we_i,
  input  logic [$clog2(WORD_W/8)-1:0] tbl_sel_i,
  input  logic [7:0]                  tbl_addr_i,
  input  logic [WORD_W-1:0]           tbl_wdata_i,
  input  logic                        start_i,
  input  logic                        decrypt_i,
  input  logic                        short_i,
  input  logic [2*WORD_W-1:0]         block_i,
  output logic [2*WORD_W-1:0]         block_o,
  output logic                        valid_o,
  output logic                        busy_o
);

  localparam int unsigned RND_W = $clog2(ROUNDS);
  localparam int unsigned ROT_W = $clog2(WORD_W);
  localparam int unsigned LANES = WORD_W / IDX_W;
  localparam logic [RND_W-1:0] FULL_LAST  = RND_W'(ROUNDS - 1);
  localparam logic [RND_W-1:0] SHORT_LAST = RND_W'(SHORT_ROUNDS - 1);

  core_state_e         state_q;
  logic [RND_W-1:0]    rnd_q;
  logic [WORD_W-1:0]   l_q, r_q, l_nxt, r_nxt;
  logic                dec_q, short_q, valid_q;
  logic [2*WORD_W-1:0] res_q;

  logic [WORD_W-1:0]       mask, half, idx, f;
  logic [ROT_W-1:0]        rot;
  logic [LANES*WORD_W-1:0] lut;
  mix_kind_e               kind;
  logic [RND_W-1:0]        last_idx;
  logic                    last_rnd;

  feistel_key_rf #(
    .WORD_W(WORD_W), .ROUNDS(ROUNDS), .ROT_W(ROT_W)
  ) u_key_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (key_we_i),
    .addr_i (key_addr_i),
    .wdata_i(key_wdata_i),
    .rnd_i  (rnd_q),
    .mask_o (mask),
    .rot_o  (rot)
  );

  feistel_lut_bank #(
    .WORD_W(WORD_W), .LANES(LANES)
  ) u_lut_bank (
    .clk_i  (clk_i),
    .we_i   (tbl_we_i),
    .sel_i  (tbl_sel_i),
    .addr_i (tbl_addr_i),
    .wdata_i(tbl_wdata_i),
    .idx_i  (idx),
    .lut_o  (lut)
  );

  feistel_round_fn #(
    .WORD_W(WORD_W), .ROT_W(ROT_W), .LANES(LANES)
  ) u_round_fn (
    .half_i(half),
    .mask_i(mask),
    .rot_i (rot),
    .kind_i(kind),
    .idx_o (idx),
    .lut_i (lut),
    .f_o   (f)
  );

  assign kind     = mix_kind_of(8'(rnd_q));
  assign half     = rnd_q[0] ? l_q : r_q;
  assign last_idx = short_q ? SHORT_LAST : FULL_LAST;
  assign last_rnd = dec_q ? (rnd_q == '0) : (rnd_q == last_idx);

  // even rounds update left, odd rounds update right, in both directions
  always_comb begin
    l_nxt = l_q;
    r_nxt = r_q;
    if (rnd_q[0]) r_nxt = r_q ^ f;
    else          l_nxt = l_q ^ f;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      l_q     <= '0;
      r_q     <= '0;
      dec_q   <= 1'b0;
      short_q <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            dec_q   <= decrypt_i;
            short_q <= short_i;
            if (decrypt_i) begin
              r_q   <= block_i[2*WORD_W-1:WORD_W];
              l_q   <= block_i[WORD_W-1:0];
              rnd_q <= short_i ? SHORT_LAST : FULL_LAST;
            end else begin
              l_q   <= block_i[2*WORD_W-1:WORD_W];
              r_q   <= block_i[WORD_W-1:0];
              rnd_q <= '0;
            end
          end
        end
        ST_RUN: begin
          l_q <= l_nxt;
          r_q <= r_nxt;
          if (last_rnd) begin
            state_q <= ST_OUT;
            valid_q <= 1'b1;
            res_q   <= dec_q ? {l_nxt, r_nxt} : {r_nxt, l_nxt};
          end else begin
            rnd_q <= dec_q ? rnd_q - 1'b1 : rnd_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign block_o = res_q;
  assign valid_o = valid_q;
  assign busy_o  = (state_q != ST_IDLE);

endmodule

// File: rtl/feistel_core_chk.sv
module feistel_core_chk #(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned ROUNDS       = 16,
  parameter int unsigned SHORT_ROUNDS = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                short_i,
  input logic [2*WORD_W-1:0] block_o,
  input logic                valid_o,
  input logic                busy_o
);

  localparam int unsigned CW = $clog2(ROUNDS) + 2;

  logic [CW-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start_i && !busy_o) begin
      cnt_q <= '0;
      lim_q <= short_i ? CW'(SHORT_ROUNDS) : CW'(ROUNDS);
    end else if (busy_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_valid_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cnt_q == lim_q));

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(block_o));

  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !valid_o));

  p_run_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !valid_o) |=> busy_o);

  p_out_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !busy_o);

endmodule

bind feistel_core feistel_core_chk #(
  .WORD_W(WORD_W), .ROUNDS(ROUNDS), .SHORT_ROUNDS(SHORT_ROUNDS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .short_i(short_i),
  .block_o(block_o),
  .valid_o(valid_o),
  .busy_o (busy_o)
);

// File: tb/feistel_core_tb_top.sv
`timescale 1ns/1ps
module feistel_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_we = 1'b0;
  logic [4:0]  key_addr = '0;
  logic [31:0] key_wdata = '0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic [7:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        start = 1'b0;
  logic        decrypt = 1'b0;
  logic        short_m = 1'b0;
  logic [63:0] blk_in = '0;
  logic [63:0] blk_out;
  logic        valid;
  logic        busy;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_tbl [4][256];
  logic [31:0] m_mask [16];
  logic [31:0] m_rot [16];

  always #4 clk = ~clk;

  feistel_core dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .key_we_i(key_we), .key_addr_i(key_addr), .key_wdata_i(key_wdata),
    .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel), .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata),
    .start_i(start), .decrypt_i(decrypt), .short_i(short_m), .block_i(blk_in),
    .block_o(blk_out), .valid_o(valid), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hash32(input logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v >> 16);
    x = x * 32'h7feb352d;
    x = x ^ (x >> 15);
    x = x * 32'h846ca68b;
    return x ^ (x >> 16);
  endfunction

  // reference round function, built from R4, R5, R6, R10
  function automatic logic [31:0] ref_f(input logic [31:0] h, input int i);
    logic [31:0] t, u, a, b, c, d;
    int amt;
    amt = int'(m_rot[i] & 32'd31);
    case (i % 3)
      0: t = m_mask[i] + h;
      1: t = m_mask[i] ^ h;
      default: t = m_mask[i] - h;
    endcase
    u = (amt == 0) ? t : ((t << amt) | (t >> (32 - amt)));
    a = m_tbl[0][u[31:24]];
    b = m_tbl[1][u[23:16]];
    c = m_tbl[2][u[15:8]];
    d = m_tbl[3][u[7:0]];
    case (i % 3)
      0: return ((a ^ b) - c) + d;
      1: return ((a - b) + c) ^ d;
      default: return ((a + b) ^ c) - d;
    endcase
  endfunction

  function automatic logic [63:0] ref_blk(input logic [63:0] x, input bit dec, input bit sh);
    logic [31:0] l, r;
    int n;
    n = sh ? 12 : 16;
    if (!dec) begin
      l = x[63:32]; r = x[31:0];
      for (int i = 0; i < n; i++) begin
        if (i % 2 == 0) l = l ^ ref_f(r, i); else r = r ^ ref_f(l, i);
      end
      return {r, l};
    end
    r = x[63:32]; l = x[31:0];
    for (int i = n - 1; i >= 0; i--) begin
      if (i % 2 == 0) l = l ^ ref_f(r, i); else r = r ^ ref_f(l, i);
    end
    return {l, r};
  endfunction

  task automatic load_tables(input bit zero);
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 256; a++) begin
        logic [31:0] v;
        v = zero ? 32'd0 : hash32(32'(s * 256 + a) ^ 32'h5a5a0000);
        m_tbl[s][a] = v;
        tbl_we = 1'b1; tbl_sel = 2'(s); tbl_addr = 8'(a); tbl_wdata = v;
        @(negedge clk);
      end
    end
    tbl_we = 1'b0;
  endtask

  // rmode: 0 random (upper bits set), 1 all zero, 2 all 31
  task automatic load_keys(input int seed, input int rmode);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] v;
      if (i < 16) begin
        v = hash32(32'(seed * 64 + i));
        m_mask[i] = v;
      end else begin
        v = (rmode == 1) ? 32'd0 : (rmode == 2) ? 32'd31 : hash32(32'(seed * 64 + i + 1000));
        m_rot[i - 16] = v;
      end
      key_we = 1'b1; key_addr = 5'(i); key_wdata = v;
      @(negedge clk);
    end
    key_we = 1'b0;
  endtask

  task automatic run_block(input logic [63:0] x, input bit dec, input bit sh,
                           output logic [63:0] res, output int lat);
    while (busy) @(negedge clk);
    start = 1'b1; blk_in = x; decrypt = dec; short_m = sh;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    res = blk_out;
    check(lat == (sh ? 12 : 16), "R8 latency", 64'(lat), sh ? 64'd12 : 64'd16);
    @(negedge clk);
    check(!valid, "R8 pulse width", 64'(valid), 64'd0);
  endtask

  task automatic test_reset();
    check(!valid, "R1 valid", 64'(valid), 64'd0);
    check(!busy, "R1 busy", 64'(busy), 64'd0);
    check(blk_out == 64'd0, "R1 block", blk_out, 64'd0);
  endtask

  task automatic test_encrypt();
    logic [63:0] pats [4];
    logic [63:0] res, exp;
    int lat;
    pats[0] = 64'h0;
    pats[1] = 64'hffff_ffff_ffff_ffff;
    pats[2] = 64'h0123_4567_89ab_cdef;
    pats[3] = 64'h8000_0000_0000_0001;
    for (int k = 0; k < 4; k++) begin
      run_block(pats[k], 1'b0, 1'b0, res, lat);
      exp = ref_blk(pats[k], 1'b0, 1'b0);
      check(res == exp, "R2 R4 R5 R6 encrypt", res, exp);
    end
  endtask

  task automatic test_decrypt();
    logic [63:0] pt, ct, res, exp;
    int lat;
    pt = 64'hdead_beef_0bad_f00d;
    ct = ref_blk(pt, 1'b0, 1'b0);
    run_block(ct, 1'b1, 1'b0, res, lat);
    check(res == pt, "R3 round trip", res, pt);
    run_block(64'h1122_3344_5566_7788, 1'b1, 1'b0, res, lat);
    exp = ref_blk(64'h1122_3344_5566_7788, 1'b1, 1'b0);
    check(res == exp, "R3 decrypt", res, exp);
  endtask

  task automatic test_short();
    logic [63:0] pt, ct, res, exp;
    int lat;
    pt = 64'h7654_3210_fedc_ba98;
    run_block(pt, 1'b0, 1'b1, res, lat);
    exp = ref_blk(pt, 1'b0, 1'b1);
    check(res == exp, "R7 short encrypt", res, exp);
    ct = res;
    run_block(ct, 1'b1, 1'b1, res, lat);
    check(res == pt, "R7 short round trip", res, pt);
  endtask

  task automatic test_rot_edges();
    logic [63:0] res, exp;
    int lat;
    load_keys(7, 1);
    run_block(64'h0f0f_f0f0_3c3c_c3c3, 1'b0, 1'b0, res, lat);
    exp = ref_blk(64'h0f0f_f0f0_3c3c_c3c3, 1'b0, 1'b0);
    check(res == exp, "R10 rotate zero", res, exp);
    load_keys(9, 2);
    run_block(64'h0f0f_f0f0_3c3c_c3c3, 1'b0, 1'b0, res, lat);
    exp = ref_blk(64'h0f0f_f0f0_3c3c_c3c3, 1'b0, 1'b0);
    check(res == exp, "R10 rotate 31", res, exp);
  endtask

  task automatic test_busy_start();
    logic [63:0] a, exp, held;
    int lat;
    bit extra;
    load_keys(3, 0);
    a = 64'hcafe_babe_1234_5678;
    exp = ref_blk(a, 1'b0, 1'b0);
    while (busy) @(negedge clk);
    start = 1'b1; blk_in = a; decrypt = 1'b0; short_m = 1'b0;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); lat++; end
    start = 1'b1; blk_in = 64'h5555_aaaa_5555_aaaa; decrypt = 1'b1; short_m = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!valid && lat < 40) begin @(negedge clk); lat++; end
    check(lat == 16, "R9 latency kept", 64'(lat), 64'd16);
    check(blk_out == exp, "R9 mid-run start ignored", blk_out, exp);
    // collide a new request with the output cycle
    held = blk_out;
    start = 1'b1; blk_in = 64'h0; decrypt = 1'b0; short_m = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R9 idle after output", 64'(busy), 64'd0);
    extra = 1'b0;
    for (int k = 0; k < 24; k++) begin
      if (valid || busy) extra = 1'b1;
      @(negedge clk);
    end
    check(!extra, "R9 start in valid cycle ignored", 64'(extra), 64'd0);
    check(blk_out == held, "R8 result held", blk_out, held);
  endtask

  task automatic test_zero_tables();
    logic [63:0] x, res;
    int lat;
    load_tables(1'b1);
    x = 64'h0011_2233_4455_6677;
    run_block(x, 1'b0, 1'b0, res, lat);
    check(res == {x[31:0], x[63:32]}, "R2 zero tables swap", res, {x[31:0], x[63:32]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    load_tables(1'b0);
    load_keys(1, 0);
    test_encrypt();
    test_decrypt();
    test_short();
    test_rot_edges();
    test_busy_start();
    test_zero_tables();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

endmodule